// File: doc/BRIEF.md
# Cycle-Skipping Raster Timing Generator

This block produces the horizontal and vertical timing of a 640x480, 60 frames per second raster. At full speed every pixel lasts two clock cycles. Clock cycles are grouped into slots of 32 positions, each slot covering 16 pixels. The slots line up with a time-multiplexed audio datapath that needs only the first 23 positions of every slot.

A 3-bit `speedup` code removes some of the 9 spare positions from each slot. This lets the chip run from a slower clock while the raster keeps its pixel geometry. Each removed position turns one pixel into a single-cycle pixel. The single-cycle pixels are always the earliest pixels of the slot, and `skip` marks them. The slot position counter `slot_cyc` counts the clocks that actually occur, so positions 0 to 22 exist in every slot whatever the code.

Every interval of a line (active 640, front porch 16, sync 96, back porch 48 pixels) is a whole number of slots. Skipping therefore shortens each interval in clocks by the same ratio. The code is taken only at a slot boundary, so no slot mixes two skip counts.

Top module: `vga_skip_timing`

## Requirements
- R1: After a synchronous active-low reset the outputs show x=0, y=0, slot_cyc=0, hsync_n=1, vsync_n=1, active=1 and skip=0. The first slot after reset uses no skipping whatever `speedup` holds.
- R2: With speedup=0, every pixel lasts exactly two clocks and skip stays low.
- R3: The number of positions removed per slot is n = speedup[1:0]*2 + speedup[2]*3. A slot then lasts 32-n clocks, so codes 0..7 give 32, 30, 28, 26, 29, 27, 25, 23 clocks.
- R4: In a slot with n removed positions, the pixels whose index inside the slot (x mod 16) is below n last one clock each, with skip=1. The remaining pixels last two clocks each, with skip=0.
- R5: slot_cyc rises by one every clock and returns to 0 on the first clock of each slot. Slots begin where x is a multiple of 16, and one slot advances x by 16.
- R6: `speedup` is sampled only on the last clock of a slot. A change in the middle of a slot does not change that slot's length or skip pattern.
- R7: x counts 0..799 and then returns to 0, and y increments exactly when x wraps. y counts 0..524 and then returns to 0.
- R8: hsync_n is low exactly when 656 <= x <= 751.
- R9: vsync_n is low exactly when y is 490 or 491. In general this is the two lines after the active lines plus the vertical front porch.
- R10: active is high exactly when x < 640 and y < 480.
- R11: With a constant code, a line lasts 50*(32-n) clocks. For example, code 0 gives 1600 clocks, code 2 gives 1400 and code 7 gives 1150.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| speedup | input | 3 | Skip code, sampled at slot end |
| x | output | 10 | Horizontal pixel counter |
| y | output | 10 | Vertical line counter |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Pixel inside the visible area |
| slot_cyc | output | 5 | Clock position inside the current slot |
| skip | output | 1 | Current pixel lasts a single clock |

## Verification
The bench walks all eight speedup codes. For each code it measures one slot's length, the number of single-cycle pixels, which pixels are single-cycle and how far x moves. This separates the weight given to each code bit, as well as a skip placed at the wrong end of the slot.

A code change in the middle of a slot shows whether the sample is taken only at the boundary. Whole-line lengths under three codes show whether the sync and porch intervals scale together.

Throughout the run, a per-clock monitor compares the sync, active, counter-step and slot-position outputs with formulas written from the requirements. The monitor runs over several frames with a shortened vertical size. A reset in the middle of a frame, with a nonzero code, confirms that the first slot after reset starts clean.

// File: rtl/vga_skip_pkg.sv
package vga_skip_pkg;

  // Positions removed from one slot for a 3-bit speed code.
  function automatic logic [3:0] skip_count(input logic [2:0] code);
    logic [3:0] two_step;
    two_step = {1'b0, code[1:0], 1'b0};
    return two_step + (code[2] ? 4'd3 : 4'd0);
  endfunction

  // Limit a skip count to the spare positions of a slot.
  function automatic logic [3:0] limit_skip(input logic [3:0] n, input int max_n);
    return (int'(n) > max_n) ? 4'(max_n) : n;
  endfunction

  // True when v lies in [lo, lo+len).
  function automatic logic in_span(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction

endpackage

// File: rtl/vga_slot_seq.sv
module vga_slot_seq #(
  parameter int SLOT_PIXELS  = 16,
  parameter int SYNTH_CYCLES = 23,
  localparam int SLOT_CYCLES = 2 * SLOT_PIXELS,
  localparam int MAX_SKIP    = SLOT_CYCLES - SYNTH_CYCLES,
  localparam int PW          = $clog2(SLOT_PIXELS),
  localparam int CW          = $clog2(SLOT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    speedup,
  input  logic [PW-1:0] px_idx,
  output logic [CW-1:0] slot_cyc,
  output logic          skip,
  output logic          pix_first,
  output logic          pix_end,
  output logic          slot_end,
  output logic [3:0]    n_cur
);
  import vga_skip_pkg::*;

  logic          phase_q;
  logic [CW-1:0] cyc_q;
  logic [3:0]    n_q;

  assign skip      = int'(px_idx) < int'(n_q);
  assign pix_first = !phase_q;
  assign pix_end   = skip || phase_q;
  assign slot_end  = pix_end && (px_idx == PW'(SLOT_PIXELS - 1));
  assign slot_cyc  = cyc_q;
  assign n_cur     = n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cyc_q   <= '0;
      n_q     <= '0;
    end else begin
      phase_q <= !pix_end;
      if (slot_end) begin
        cyc_q <= '0;
        n_q   <= limit_skip(skip_count(speedup), MAX_SKIP);
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vga_pixel_count.sv
module vga_pixel_count #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  localparam int XW = $clog2(H_TOTAL),
  localparam int YW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_last;
  logic          y_last;

  assign x_last = x_q == XW'(H_TOTAL - 1);
  assign y_last = y_q == YW'(V_TOTAL - 1);
  assign x = x_q;
  assign y = y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (x_last) begin
        x_q <= '0;
        y_q <= y_last ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vga_sync_decode.sv
module vga_sync_decode #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int XW       = 10,
  parameter int YW       = 10
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active
);
  import vga_skip_pkg::*;

  assign hsync_n = !in_span(int'(x), H_ACTIVE + H_FP, H_SYNC);
  assign vsync_n = !in_span(int'(y), V_ACTIVE + V_FP, V_SYNC);
  assign active  = in_span(int'(x), 0, H_ACTIVE) && in_span(int'(y), 0, V_ACTIVE);
endmodule

// File: rtl/vga_skip_timing.sv
module vga_skip_timing #(
  parameter int H_ACTIVE     = 640,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_ACTIVE     = 480,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 33,
  parameter int SLOT_PIXELS  = 16,
  parameter int SYNTH_CYCLES = 23,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int XW      = $clog2(H_TOTAL),
  localparam int YW      = $clog2(V_TOTAL),
  localparam int PW      = $clog2(SLOT_PIXELS),
  localparam int CW      = $clog2(2 * SLOT_PIXELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    speedup,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic [CW-1:0] slot_cyc,
  output logic          skip
);
  // Named internal events, observed by the bound checker.
  logic       pix_first;
  logic       pix_end;
  logic       slot_end;
  logic [3:0] n_cur;

  vga_slot_seq #(
    .SLOT_PIXELS (SLOT_PIXELS),
    .SYNTH_CYCLES(SYNTH_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .speedup  (speedup),
    .px_idx   (x[PW-1:0]),
    .slot_cyc (slot_cyc),
    .skip     (skip),
    .pix_first(pix_first),
    .pix_end  (pix_end),
    .slot_end (slot_end),
    .n_cur    (n_cur)
  );

  vga_pixel_count #(
    .H_TOTAL(H_TOTAL),
    .V_TOTAL(V_TOTAL)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (pix_end),
    .x    (x),
    .y    (y)
  );

  vga_sync_decode #(
    .H_ACTIVE(H_ACTIVE),
    .H_FP    (H_FP),
    .H_SYNC  (H_SYNC),
    .V_ACTIVE(V_ACTIVE),
    .V_FP    (V_FP),
    .V_SYNC  (V_SYNC),
    .XW      (XW),
    .YW      (YW)
  ) u_sync (
    .x      (x),
    .y      (y),
    .hsync_n(hsync_n),
    .vsync_n(vsync_n),
    .active (active)
  );
endmodule

// File: rtl/vga_skip_timing_chk.sv
module vga_skip_timing_chk #(
  parameter int H_ACTIVE    = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_TOTAL     = 800,
  parameter int V_ACTIVE    = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int SLOT_PIXELS = 16,
  parameter int XW          = 10,
  parameter int YW          = 10,
  parameter int CW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          active,
  input logic [CW-1:0] slot_cyc,
  input logic          skip,
  input logic          pix_first,
  input logic          pix_end,
  input logic          slot_end,
  input logic [3:0]    n_cur
);
  p_px_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip && pix_first) |=> $stable(x));

  p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (int'(slot_cyc) == 2 * SLOT_PIXELS - 1 - int'(n_cur)));

  p_single_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> (x != $past(x)));

  p_slot_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (slot_cyc == '0));

  p_sample_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(n_cur));

  p_xwrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(x) == H_TOTAL - 1 && pix_end) |=> (x == '0));

  p_hsync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(x) == H_ACTIVE + H_FP - 1 && pix_end) |=> !hsync_n);

  p_hsync_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(x) == H_ACTIVE + H_FP + H_SYNC - 1 && pix_end) |=> hsync_n);

  p_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(y) == V_ACTIVE + V_FP) |-> !vsync_n);

  p_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(x) < H_ACTIVE && int'(y) < V_ACTIVE));
endmodule

bind vga_skip_timing vga_skip_timing_chk #(
  .H_ACTIVE   (H_ACTIVE),
  .H_FP       (H_FP),
  .H_SYNC     (H_SYNC),
  .H_TOTAL    (H_TOTAL),
  .V_ACTIVE   (V_ACTIVE),
  .V_FP       (V_FP),
  .V_SYNC     (V_SYNC),
  .SLOT_PIXELS(SLOT_PIXELS),
  .XW         (XW),
  .YW         (YW),
  .CW         (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .x        (x),
  .y        (y),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .active   (active),
  .slot_cyc (slot_cyc),
  .skip     (skip),
  .pix_first(pix_first),
  .pix_end  (pix_end),
  .slot_end (slot_end),
  .n_cur    (n_cur)
);

// File: tb/vga_skip_timing_bench.sv
module vga_skip_timing_bench;
  localparam int CLK_PERIOD = 10;
  // Horizontal at full size; vertical shortened so frames stay brief.
  localparam int HA = 640, HF = 16, HS = 96, HB = 48;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);

  // Table: code, expected removed positions, expected slot clocks.
  localparam int VEC_CODE [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_N    [8] = '{0, 2, 4, 6, 3, 5, 7, 9};
  localparam int VEC_LEN  [8] = '{32, 30, 28, 26, 29, 27, 25, 23};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    speedup = 3'd0;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic          hsync_n, vsync_n, active, skip;
  logic [4:0]    slot_cyc;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vga_skip_timing #(
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u_vga_skip_timing (
    .clk(clk), .rst_n(rst_n), .speedup(speedup),
    .x(x), .y(y), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .slot_cyc(slot_cyc), .skip(skip)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-clock monitor against formulas from R5, R7, R8, R9, R10.
  logic mon_en = 1'b0;
  logic have_prev = 1'b0;
  int px, py, ps;
  int mm_h = 0, mm_v = 0, mm_a = 0, mm_x = 0, mm_y = 0, mm_s = 0;
  int seen_vlow = 0, y_wraps = 0, samples = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      samples++;
      if (hsync_n != !(int'(x) >= HA + HF && int'(x) < HA + HF + HS)) mm_h++;
      if (vsync_n != !(int'(y) >= VA + VF && int'(y) < VA + VF + VS)) mm_v++;
      if (active != (int'(x) < HA && int'(y) < VA)) mm_a++;
      if (!vsync_n) seen_vlow++;
      if (have_prev) begin
        if (int'(x) != px && int'(x) != px + 1 && !(px == HT - 1 && x == 0)) mm_x++;
        if (px == HT - 1 && x == 0) begin
          if (int'(y) != (py + 1) % VT) mm_y++;
          if (py == VT - 1) y_wraps++;
        end else if (int'(y) != py) mm_y++;
        if (int'(slot_cyc) != ps + 1 &&
            !(slot_cyc == 0 && x[3:0] == 0 && int'(x) != px)) mm_s++;
      end
      px = int'(x); py = int'(y); ps = int'(slot_cyc);
      have_prev = 1'b1;
    end else begin
      have_prev = 1'b0;
    end
  end

  task automatic align_slot();
    @(negedge clk);
    while (slot_cyc != 0) @(negedge clk);
  endtask

  // Measure one slot starting at its first clock.
  task automatic measure_slot(input int exp_n, output int clocks, output int skips,
                              output int bad_flag, output int bad_dur, output int x_adv);
    int durs [16];
    int x0;
    for (int i = 0; i < 16; i++) durs[i] = 0;
    clocks = 0; skips = 0; bad_flag = 0; bad_dur = 0;
    x0 = int'(x);
    do begin
      if (skip) skips++;
      durs[x[3:0]]++;
      if (skip != (int'(x[3:0]) < exp_n)) bad_flag++;
      @(negedge clk);
      clocks++;
    end while (slot_cyc != 0 && clocks < 40);
    for (int i = 0; i < 16; i++)
      if (durs[i] != ((i < exp_n) ? 1 : 2)) bad_dur++;
    x_adv = (int'(x) - x0 + HT) % HT;
  endtask

  task automatic measure_line(input logic [2:0] code, output int clocks);
    int yy;
    speedup = code;
    yy = int'(y);
    while (int'(y) == yy) @(negedge clk);
    yy = int'(y);
    clocks = 0;
    while (int'(y) == yy) begin
      @(negedge clk);
      clocks++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    int clocks, skips, bad_flag, bad_dur, x_adv, len;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "x after reset", int'(x), 0);
    chk("R1", "y after reset", int'(y), 0);
    chk("R1", "slot_cyc after reset", int'(slot_cyc), 0);
    chk("R1", "hsync_n/vsync_n/active/skip", {hsync_n, vsync_n, active, skip}, 4'b1110);
    mon_en = 1'b1;

    // R2, R3, R4, R5: table walk over all codes
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      speedup = 3'(VEC_CODE[v]);
      align_slot();
      measure_slot(VEC_N[v], clocks, skips, bad_flag, bad_dur, x_adv);
      chk("R3", $sformatf("slot clocks code %0d", VEC_CODE[v]), clocks, VEC_LEN[v]);
      chk("R4", $sformatf("skip count code %0d", VEC_CODE[v]), skips, VEC_N[v]);
      chk("R4", $sformatf("skip placement code %0d", VEC_CODE[v]), bad_flag, 0);
      chk(VEC_CODE[v] == 0 ? "R2" : "R4",
          $sformatf("pixel durations code %0d", VEC_CODE[v]), bad_dur, 0);
      chk("R5", $sformatf("x advance per slot code %0d", VEC_CODE[v]), x_adv, 16);
    end

    // R6: code change in the middle of a slot
    @(negedge clk);
    speedup = 3'd0;
    align_slot();
    while (slot_cyc != 5) @(negedge clk);
    speedup = 3'd7;
    measure_slot(0, clocks, skips, bad_flag, bad_dur, x_adv);
    chk("R6", "slot clocks after mid-slot change", clocks + 5, 32);
    chk("R6", "skips after mid-slot change", skips, 0);
    measure_slot(9, clocks, skips, bad_flag, bad_dur, x_adv);
    chk("R6", "next slot takes new code", clocks, 23);

    // R11: line lengths under three codes
    measure_line(3'd0, len); chk("R11", "line clocks code 0", len, 1600);
    measure_line(3'd2, len); chk("R11", "line clocks code 2", len, 1400);
    measure_line(3'd7, len); chk("R11", "line clocks code 7", len, 1150);

    // Run two full frames at the fastest code for the monitor
    repeat (2 * VT * 1150 + 200) @(negedge clk);

    // R1: reset in the middle of a frame with a nonzero code
    mon_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "x,y after mid-frame reset", int'(x) + int'(y), 0);
    chk("R1", "skip low in first slot despite code 7", int'(skip), 0);
    measure_slot(0, clocks, skips, bad_flag, bad_dur, x_adv);
    chk("R1", "first slot after reset clocks", clocks, 32);

    chk("R5", "slot_cyc step mismatches", mm_s, 0);
    chk("R7", "x step mismatches", mm_x, 0);
    chk("R7", "y step mismatches", mm_y, 0);
    chk("R7", "y wraps observed", int'(y_wraps > 0), 1);
    chk("R8", "hsync mismatches", mm_h, 0);
    chk("R9", "vsync mismatches", mm_v, 0);
    chk("R9", "vsync low observed", int'(seen_vlow > 0), 1);
    chk("R10", "active mismatches", mm_a, 0);
    chk("R10", "monitor sampled", int'(samples > 10000), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule